// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Stack

This block keeps the control-flow state of one 32-thread SIMT warp. The threads share a single program counter. When a branch sends some active threads one way and the rest another, the block runs the two groups one after the other, each with its own thread mask. When both groups reach the reconvergence point supplied with the branch, it merges them back into a single group.

The state is held in a stack. Each entry has three fields: the PC to fetch next, the PC at which the entry's threads rejoin, and the mask of the threads it owns. The warp always fetches from the top entry, with that entry's mask.

The pipeline reports each retired instruction with a one-cycle `step` pulse:
- For a plain instruction, `step` carries the PC the warp moves to.
- For a branch, `step` carries the per-thread taken mask, the target PC, the fall-through PC and the reconvergence PC.

A `start` pulse loads a new warp with every thread active.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `fetch_pc` is 0, `active_mask` is 0, `stack_depth` is 0 and `overflow` is 0.
- R2: A `start` pulse makes the next cycle show `fetch_pc` equal to `start_pc`, `active_mask` all ones, `stack_depth` 1 and `overflow` 0. The base entry's reconvergence PC is all ones.
- R3: A `step` with `is_branch` low sets `fetch_pc` to `adv_pc` in the next cycle and leaves `active_mask` and `stack_depth` unchanged, unless R6–R8 pop.
- R4: A uniform branch pushes nothing and leaves `active_mask` and `stack_depth` unchanged. The taken set is `taken_mask & active_mask` and the fall-through set is `~taken_mask & active_mask`. If the taken set is empty, `fetch_pc` becomes `fallthru_pc`. Otherwise, if the fall-through set is empty, `fetch_pc` becomes `target_pc`. Taken bits of inactive threads have no effect.
- R5: A divergent branch (both sets non-empty) does three things in one update. It rewrites the top entry's next PC to `reconv_pc`. It pushes the fall-through entry {`fallthru_pc`, `reconv_pc`, fall-through set}. It then pushes the taken entry {`target_pc`, `reconv_pc`, taken set}. The next cycle shows `fetch_pc` = `target_pc`, `active_mask` = taken set and `stack_depth` + 2.
- R6: When the taken entry's next PC reaches its reconvergence PC, that entry is popped. The fall-through entry then runs with its own PC and mask.
- R7: When the last path entry of a branch is popped, the entry below resumes at the reconvergence PC with its full mask.
- R8: Pops cascade within the same update while the new top's next PC equals its reconvergence PC. This covers an entry pushed with its target already equal to the reconvergence PC, and nested branches that share a reconvergence PC.
- R9: A divergent branch with fewer than two free entries (`stack_depth` + 2 > `DEPTH`) leaves the stack unchanged and sets `overflow`. `overflow` stays set until the next `start`.
- R10: The base entry (depth 1) is never popped, even when its next PC equals its reconvergence PC.
- R11: `step` has no effect before the first `start`. When `start` and `step` arrive together, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load a new warp, all threads active |
| start_pc | input | PC_W | First PC of the new warp |
| step | input | 1 | One instruction of the warp retired this cycle |
| is_branch | input | 1 | The retired instruction is a conditional branch |
| adv_pc | input | PC_W | PC after a non-branch instruction |
| taken_mask | input | THREADS | Per-thread branch outcome, 1 = taken |
| target_pc | input | PC_W | Branch target PC |
| fallthru_pc | input | PC_W | PC after a not-taken branch |
| reconv_pc | input | PC_W | Reconvergence PC for the branch |
| fetch_pc | output | PC_W | PC the warp fetches next |
| active_mask | output | THREADS | Threads enabled at `fetch_pc` |
| stack_depth | output | $clog2(DEPTH+1) | Number of live entries, 0 when idle |
| overflow | output | 1 | Sticky: a split found no room |

## Verification
Every result is registered. The effect of a `start` or `step` presented in one cycle appears on `fetch_pc`, `active_mask`, `stack_depth` and `overflow` right after the next rising edge. Cascaded pops complete at that same edge and never take extra cycles.

The bench changes inputs on the falling edge and holds each pulse for exactly one rising edge. It reads all four outputs at the following falling edge, so each comparison sees exactly one update. The clocked properties use a one-cycle `|=>` to match this single-cycle latency.

// File: rtl/simt_stack_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the warp divergence stack.
// Assumes nothing beyond SystemVerilog-2017.
package simt_stack_pkg;

    // How a retired instruction changes the warp's control flow.
    typedef enum logic [1:0] {
        FLOW_SEQ      = 2'd0,  // not a branch
        FLOW_ALL_FALL = 2'd1,  // no active thread took the branch
        FLOW_ALL_TAKE = 2'd2,  // every active thread took it
        FLOW_SPLIT    = 2'd3   // both paths have threads
    } flow_kind_e;

endpackage

// File: rtl/simt_path_split.sv
`timescale 1ns/1ps
// Module: simt_path_split
// Splits the active mask of the top entry into the taken and
// fall-through thread sets of a branch, and classifies the step.
// Assumes taken bits of inactive threads are meaningless (masked off).
module simt_path_split
    import simt_stack_pkg::*;
#(
    parameter int THREADS = 32
) (
    input  logic               is_branch,
    input  logic [THREADS-1:0] cur_mask,
    input  logic [THREADS-1:0] taken_mask,
    output logic [THREADS-1:0] take_set,
    output logic [THREADS-1:0] fall_set,
    output flow_kind_e         kind
);

    // Restrict the outcome to threads that are running.
    always_comb begin
        take_set = taken_mask & cur_mask;
        fall_set = ~taken_mask & cur_mask;
    end

    // Empty taken set wins, so an empty warp simply falls through.
    always_comb begin
        if (!is_branch)
            kind = FLOW_SEQ;
        else if (take_set == '0)
            kind = FLOW_ALL_FALL;
        else if (fall_set == '0)
            kind = FLOW_ALL_TAKE;
        else
            kind = FLOW_SPLIT;
    end

endmodule

// File: rtl/simt_stack_store.sv
`timescale 1ns/1ps
// Module: simt_stack_store
// Register array of DEPTH stack entries {next PC, reconvergence PC, mask}.
// Each entry has its own write enable; all entries are readable at once.
// Assumes the caller never writes an entry it does not own.
module simt_stack_store #(
    parameter int THREADS = 32,
    parameter int PC_W    = 32,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH-1:0]   wr_en,
    input  logic [PC_W-1:0]    wr_next [DEPTH],
    input  logic [PC_W-1:0]    wr_rpc  [DEPTH],
    input  logic [THREADS-1:0] wr_mask [DEPTH],
    output logic [PC_W-1:0]    rd_next [DEPTH],
    output logic [PC_W-1:0]    rd_rpc  [DEPTH],
    output logic [THREADS-1:0] rd_mask [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one entry; clear on reset, load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_next[g] <= '0;
                rd_rpc[g]  <= '0;
                rd_mask[g] <= '0;
            end else if (wr_en[g]) begin
                rd_next[g] <= wr_next[g];
                rd_rpc[g]  <= wr_rpc[g];
                rd_mask[g] <= wr_mask[g];
            end
        end
    end

endmodule

// File: rtl/simt_pop_scan.sv
`timescale 1ns/1ps
// Module: simt_pop_scan
// Given the candidate stack after this cycle's update, finds the top
// index left once every entry whose next PC equals its reconvergence
// PC has been popped from the top down. Entry 0 is never popped.
// Assumes cand_top < DEPTH.
module simt_pop_scan #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [PC_W-1:0]  cand_next [DEPTH],
    input  logic [PC_W-1:0]  cand_rpc  [DEPTH],
    input  logic [IDX_W-1:0] cand_top,
    output logic [IDX_W-1:0] final_top
);

    logic [DEPTH-1:0] keep;

    // An entry survives if it has not yet reached its reconvergence PC.
    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        assign keep[g] = (g == 0) || (cand_next[g] != cand_rpc[g]);
    end

    // Highest surviving entry at or below the candidate top.
    always_comb begin
        final_top = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (i <= int'(cand_top) && keep[i])
                final_top = IDX_W'(i);
        end
    end

endmodule

// File: rtl/simt_reconv_stack.sv
`timescale 1ns/1ps
// Module: simt_reconv_stack (top)
// Per-warp divergence stack. The warp fetches from the top entry. A
// divergent branch parks the top at the reconvergence PC and pushes a
// fall-through then a taken entry; entries pop when they reach their
// reconvergence PC. One update per step, all outputs registered.
// Assumes DEPTH >= 3 and a single-cycle step pulse per instruction.
module simt_reconv_stack
    import simt_stack_pkg::*;
#(
    parameter int THREADS = 32,
    parameter int PC_W    = 32,
    parameter int DEPTH   = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DEP_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PC_W-1:0]    start_pc,
    input  logic               step,
    input  logic               is_branch,
    input  logic [PC_W-1:0]    adv_pc,
    input  logic [THREADS-1:0] taken_mask,
    input  logic [PC_W-1:0]    target_pc,
    input  logic [PC_W-1:0]    fallthru_pc,
    input  logic [PC_W-1:0]    reconv_pc,
    output logic [PC_W-1:0]    fetch_pc,
    output logic [THREADS-1:0] active_mask,
    output logic [DEP_W-1:0]   stack_depth,
    output logic               overflow
);

    logic [IDX_W-1:0]   tos;
    logic               live;
    logic               ovf_q;

    logic [DEPTH-1:0]   w_en;
    logic [PC_W-1:0]    w_next [DEPTH];
    logic [PC_W-1:0]    w_rpc  [DEPTH];
    logic [THREADS-1:0] w_mask [DEPTH];
    logic [PC_W-1:0]    st_next [DEPTH];
    logic [PC_W-1:0]    st_rpc  [DEPTH];
    logic [THREADS-1:0] st_mask [DEPTH];
    logic [PC_W-1:0]    cand_next [DEPTH];
    logic [PC_W-1:0]    cand_rpc  [DEPTH];

    logic [THREADS-1:0] top_mask;
    logic [PC_W-1:0]    top_next;
    logic [THREADS-1:0] take_set;
    logic [THREADS-1:0] fall_set;
    flow_kind_e         kind;
    logic               room;
    logic               split_go;
    logic               ovf_hit;
    logic               upd_go;
    logic [PC_W-1:0]    new_top_next;
    logic [IDX_W-1:0]   cand_top;
    logic [IDX_W-1:0]   fin_top;

    // Entry storage.
    simt_stack_store #(
        .THREADS(THREADS), .PC_W(PC_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(w_en), .wr_next(w_next), .wr_rpc(w_rpc), .wr_mask(w_mask),
        .rd_next(st_next), .rd_rpc(st_rpc), .rd_mask(st_mask)
    );

    // Read the current top entry.
    always_comb begin
        top_next = st_next[tos];
        top_mask = st_mask[tos];
    end

    // Branch outcome against the running threads.
    simt_path_split #(.THREADS(THREADS)) u_split (
        .is_branch(is_branch), .cur_mask(top_mask), .taken_mask(taken_mask),
        .take_set(take_set), .fall_set(fall_set), .kind(kind)
    );

    // Decide whether this step updates, splits or overflows.
    always_comb begin
        room     = (int'(tos) + 2) < DEPTH;
        upd_go   = step && live && !start;
        split_go = upd_go && (kind == FLOW_SPLIT) && room;
        ovf_hit  = upd_go && (kind == FLOW_SPLIT) && !room;
        cand_top = split_go ? IDX_W'(int'(tos) + 2) : tos;
    end

    // New next PC of the entry that is on top now.
    always_comb begin
        unique case (kind)
            FLOW_SEQ:      new_top_next = adv_pc;
            FLOW_ALL_FALL: new_top_next = fallthru_pc;
            FLOW_ALL_TAKE: new_top_next = target_pc;
            default:       new_top_next = reconv_pc;
        endcase
    end

    // Build the entry writes and the candidate stack seen by the pop scan.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            w_en[i]      = 1'b0;
            w_next[i]    = new_top_next;
            w_rpc[i]     = st_rpc[i];
            w_mask[i]    = st_mask[i];
            cand_next[i] = st_next[i];
            cand_rpc[i]  = st_rpc[i];
            if (i == int'(tos))
                cand_next[i] = new_top_next;
            if (split_go && i == int'(tos) + 1) begin
                cand_next[i] = fallthru_pc;
                cand_rpc[i]  = reconv_pc;
            end
            if (split_go && i == int'(tos) + 2) begin
                cand_next[i] = target_pc;
                cand_rpc[i]  = reconv_pc;
            end
            if (start) begin
                if (i == 0) begin
                    w_en[i]   = 1'b1;
                    w_next[i] = start_pc;
                    w_rpc[i]  = '1;
                    w_mask[i] = '1;
                end
            end else if (upd_go && !ovf_hit) begin
                if (i == int'(tos)) begin
                    w_en[i] = 1'b1;
                end
                if (split_go && i == int'(tos) + 1) begin
                    w_en[i]   = 1'b1;
                    w_next[i] = fallthru_pc;
                    w_rpc[i]  = reconv_pc;
                    w_mask[i] = fall_set;
                end
                if (split_go && i == int'(tos) + 2) begin
                    w_en[i]   = 1'b1;
                    w_next[i] = target_pc;
                    w_rpc[i]  = reconv_pc;
                    w_mask[i] = take_set;
                end
            end
        end
    end

    // Cascaded pop of finished entries.
    simt_pop_scan #(.PC_W(PC_W), .DEPTH(DEPTH)) u_pop (
        .cand_next(cand_next), .cand_rpc(cand_rpc),
        .cand_top(cand_top), .final_top(fin_top)
    );

    // Top pointer, warp-loaded flag and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos   <= '0;
            live  <= 1'b0;
            ovf_q <= 1'b0;
        end else if (start) begin
            tos   <= '0;
            live  <= 1'b1;
            ovf_q <= 1'b0;
        end else if (ovf_hit) begin
            ovf_q <= 1'b1;
        end else if (upd_go) begin
            tos   <= fin_top;
        end
    end

    // Present the top entry, or zeros while no warp is loaded.
    always_comb begin
        fetch_pc    = live ? top_next : '0;
        active_mask = live ? top_mask : '0;
        stack_depth = live ? DEP_W'(int'(tos) + 1) : '0;
        overflow    = ovf_q;
    end

endmodule

// File: rtl/simt_reconv_stack_chk.sv
`timescale 1ns/1ps
// Module: simt_reconv_stack_chk
// Port-level properties of the divergence stack, bound to the top.
// Assumes the synchronous active-low reset of the top.
module simt_reconv_stack_chk #(
    parameter int THREADS = 32,
    parameter int PC_W    = 32,
    parameter int DEPTH   = 8,
    localparam int DEP_W  = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [PC_W-1:0]    start_pc,
    input logic               step,
    input logic               is_branch,
    input logic [PC_W-1:0]    adv_pc,
    input logic [THREADS-1:0] taken_mask,
    input logic [PC_W-1:0]    fetch_pc,
    input logic [THREADS-1:0] active_mask,
    input logic [DEP_W-1:0]   stack_depth,
    input logic               overflow
);

    logic both_paths;
    logic full_for_split;

    // Observed branch split and lack of room, from ports only.
    always_comb begin
        both_paths     = ((taken_mask & active_mask) != '0) &&
                         ((~taken_mask & active_mask) != '0);
        full_for_split = (int'(stack_depth) + 2) > DEPTH;
    end

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fetch_pc == $past(start_pc)) && (active_mask == '1) &&
                  (stack_depth == DEP_W'(1)) && !overflow);

    p_seq_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && !is_branch && stack_depth == DEP_W'(1))
        |=> (fetch_pc == $past(adv_pc)) && $stable(active_mask));

    p_split_growth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && is_branch && both_paths && !full_for_split)
        |=> (int'(stack_depth) <= int'($past(stack_depth)) + 2));

    p_live_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_depth != '0) |-> (active_mask != '0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && stack_depth != '0 && is_branch && both_paths &&
         full_for_split)
        |=> overflow && $stable(fetch_pc) && $stable(active_mask) &&
            $stable(stack_depth));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stack_depth) <= DEPTH);

    p_base_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_depth != '0 && !start) |=> (stack_depth != '0));

    p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_depth == '0 && !start) |=> (stack_depth == '0) &&
                                          (active_mask == '0));

endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .THREADS(THREADS), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .step(step), .is_branch(is_branch), .adv_pc(adv_pc),
    .taken_mask(taken_mask), .fetch_pc(fetch_pc),
    .active_mask(active_mask), .stack_depth(stack_depth),
    .overflow(overflow)
);

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed corner cases.
module simt_reconv_stack_test;

    localparam int T = 32;
    localparam int P = 32;
    localparam int D = 8;
    localparam int NV = 21;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;     // 0 start, 1 plain step, 2 branch
        logic [31:0] a;      // start_pc / adv_pc / target_pc
        logic [31:0] ft;
        logic [31:0] rc;
        logic [31:0] tk;
        logic [31:0] epc;
        logic [31:0] emask;
        logic [3:0]  edep;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd2, 2'd0, 32'h100, 32'h0,   32'h0,   32'h0,        32'h100, 32'hFFFFFFFF, 4'd1}, // R2
        '{4'd3, 2'd1, 32'h104, 32'h0,   32'h0,   32'h0,        32'h104, 32'hFFFFFFFF, 4'd1}, // R3
        '{4'd4, 2'd2, 32'h200, 32'h108, 32'h300, 32'hFFFFFFFF, 32'h200, 32'hFFFFFFFF, 4'd1}, // R4
        '{4'd4, 2'd2, 32'h400, 32'h204, 32'h300, 32'h0,        32'h204, 32'hFFFFFFFF, 4'd1}, // R4
        '{4'd5, 2'd2, 32'h240, 32'h208, 32'h280, 32'h0000FFFF, 32'h240, 32'h0000FFFF, 4'd3}, // R5
        '{4'd3, 2'd1, 32'h244, 32'h0,   32'h0,   32'h0,        32'h244, 32'h0000FFFF, 4'd3}, // R3
        '{4'd6, 2'd1, 32'h280, 32'h0,   32'h0,   32'h0,        32'h208, 32'hFFFF0000, 4'd2}, // R6
        '{4'd3, 2'd1, 32'h20C, 32'h0,   32'h0,   32'h0,        32'h20C, 32'hFFFF0000, 4'd2}, // R3
        '{4'd7, 2'd1, 32'h280, 32'h0,   32'h0,   32'h0,        32'h280, 32'hFFFFFFFF, 4'd1}, // R7
        '{4'd5, 2'd2, 32'h500, 32'h300, 32'h600, 32'h0000000F, 32'h500, 32'h0000000F, 4'd3}, // R5
        '{4'd5, 2'd2, 32'h510, 32'h504, 32'h600, 32'h00000003, 32'h510, 32'h00000003, 4'd5}, // R5 nested
        '{4'd6, 2'd1, 32'h600, 32'h0,   32'h0,   32'h0,        32'h504, 32'h0000000C, 4'd4}, // R6
        '{4'd8, 2'd1, 32'h600, 32'h0,   32'h0,   32'h0,        32'h300, 32'hFFFFFFF0, 4'd2}, // R8 two pops
        '{4'd7, 2'd1, 32'h600, 32'h0,   32'h0,   32'h0,        32'h600, 32'hFFFFFFFF, 4'd1}, // R7
        '{4'd8, 2'd2, 32'h700, 32'h610, 32'h700, 32'h000000FF, 32'h610, 32'hFFFFFF00, 4'd2}, // R8 target==rc
        '{4'd7, 2'd1, 32'h700, 32'h0,   32'h0,   32'h0,        32'h700, 32'hFFFFFFFF, 4'd1}, // R7
        '{4'd5, 2'd2, 32'h800, 32'h704, 32'h900, 32'h0000000F, 32'h800, 32'h0000000F, 4'd3}, // R5
        '{4'd4, 2'd2, 32'h880, 32'h804, 32'h900, 32'hFFFFFFF0, 32'h804, 32'h0000000F, 4'd3}, // R4 inactive bits
        '{4'd4, 2'd2, 32'h880, 32'h808, 32'h900, 32'hFFFFFFFF, 32'h880, 32'h0000000F, 4'd3}, // R4
        '{4'd6, 2'd1, 32'h900, 32'h0,   32'h0,   32'h0,        32'h704, 32'hFFFFFFF0, 4'd2}, // R6
        '{4'd7, 2'd1, 32'h900, 32'h0,   32'h0,   32'h0,        32'h900, 32'hFFFFFFFF, 4'd1}  // R7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [P-1:0] start_pc = '0;
    logic         step = 1'b0;
    logic         is_branch = 1'b0;
    logic [P-1:0] adv_pc = '0;
    logic [T-1:0] taken_mask = '0;
    logic [P-1:0] target_pc = '0;
    logic [P-1:0] fallthru_pc = '0;
    logic [P-1:0] reconv_pc = '0;
    logic [P-1:0] fetch_pc;
    logic [T-1:0] active_mask;
    logic [3:0]   stack_depth;
    logic         overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simt_reconv_stack #(.THREADS(T), .PC_W(P), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .step(step), .is_branch(is_branch), .adv_pc(adv_pc),
        .taken_mask(taken_mask), .target_pc(target_pc),
        .fallthru_pc(fallthru_pc), .reconv_pc(reconv_pc),
        .fetch_pc(fetch_pc), .active_mask(active_mask),
        .stack_depth(stack_depth), .overflow(overflow)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [31:0] epc, logic [31:0] emask,
                             logic [3:0] edep, logic eovf);
        check(req, "fetch_pc", fetch_pc, epc);
        check(req, "active_mask", active_mask, emask);
        check(req, "stack_depth", 32'(stack_depth), 32'(edep));
        check(req, "overflow", 32'(overflow), 32'(eovf));
    endtask

    // Present one cycle of stimulus at a falling edge, sample one cycle later.
    task automatic drive(bit st, bit sp, bit br, logic [31:0] a, logic [31:0] ft,
                         logic [31:0] rc, logic [31:0] tk);
        @(negedge clk);
        start       = st;
        start_pc    = a;
        step        = sp;
        is_branch   = br;
        adv_pc      = a;
        target_pc   = a;
        fallthru_pc = ft;
        reconv_pc   = rc;
        taken_mask  = tk;
        @(negedge clk);
        start = 1'b0;
        step  = 1'b0;
        is_branch = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 32'h0, 32'h0, 4'd0, 1'b0);

        // R11: steps before any start do nothing.
        drive(1'b0, 1'b1, 1'b0, 32'h55, 32'h0, 32'h0, 32'h0);
        check_all("R11", 32'h0, 32'h0, 4'd0, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 32'h66, 32'h70, 32'h80, 32'h0000FFFF);
        check_all("R11", 32'h0, 32'h0, 4'd0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].op == 2'd0, VEC[k].op != 2'd0, VEC[k].op == 2'd2,
                  VEC[k].a, VEC[k].ft, VEC[k].rc, VEC[k].tk);
            check_all($sformatf("R%0d vec%0d", VEC[k].req, k),
                      VEC[k].epc, VEC[k].emask, VEC[k].edep, 1'b0);
        end

        // R10: base entry reaching its all-ones reconvergence PC stays.
        drive(1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0);
        check_all("R10", 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd1, 1'b0);

        // R9: fill the stack with three nested splits, the fourth overflows.
        drive(1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
        check_all("R2", 32'h0, 32'hFFFFFFFF, 4'd1, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 32'hA00, 32'hA04, 32'hF00, 32'h0000FFFF);
        check_all("R5", 32'hA00, 32'h0000FFFF, 4'd3, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 32'hA10, 32'hA14, 32'hE00, 32'h000000FF);
        check_all("R5", 32'hA10, 32'h000000FF, 4'd5, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 32'hA20, 32'hA24, 32'hD00, 32'h0000000F);
        check_all("R5", 32'hA20, 32'h0000000F, 4'd7, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 32'hA30, 32'hA34, 32'hC00, 32'h00000003);
        check_all("R9", 32'hA20, 32'h0000000F, 4'd7, 1'b1);
        drive(1'b0, 1'b1, 1'b0, 32'hA28, 32'h0, 32'h0, 32'h0);
        check_all("R9", 32'hA28, 32'h0000000F, 4'd7, 1'b1);
        // Uniform branch still works when full (needs no room).
        drive(1'b0, 1'b1, 1'b1, 32'hB00, 32'hA2C, 32'hC00, 32'h0000000F);
        check_all("R9", 32'hB00, 32'h0000000F, 4'd7, 1'b1);

        // R11: start together with step; start wins and clears overflow.
        @(negedge clk);
        start = 1'b1; start_pc = 32'h40;
        step = 1'b1; is_branch = 1'b0; adv_pc = 32'h77;
        @(negedge clk);
        start = 1'b0; step = 1'b0;
        check_all("R11", 32'h40, 32'hFFFFFFFF, 4'd1, 1'b0);

        // R1: reset in the middle of a split returns to idle.
        drive(1'b0, 1'b1, 1'b1, 32'hC00, 32'hC04, 32'hC80, 32'h0000FFFF);
        check_all("R5", 32'hC00, 32'h0000FFFF, 4'd3, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", 32'h0, 32'h0, 4'd0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule